// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the device end of a three-wire synchronous port: a chip-enable, a serial clock and one bidirectional data line, all sampled in the system clock domain. Each transfer opens with a command byte sent least significant bit first. The command selects clock space or scratch RAM space, an address and a direction. Data bytes then follow, shifted in or out. Clock space holds seven time bytes, a control byte that carries the write-protect flag, and one auxiliary configuration byte. RAM space holds 31 scratch bytes. Address 31 in either space starts a burst.

The time bytes live in an external time counter. The block reaches that counter through a snapshot bus (`live_time`) and a load strobe with a byte mask. The live bytes are copied into user buffers when chip-enable rises. Written time bytes are handed back to the counter when chip-enable falls, so a transfer always sees one coherent time value. The data pin is modelled as `dio_out` plus an output enable `dio_oe`.

The serial engine has five states. ST_IDLE is entered whenever chip-enable is low. ST_CMD collects the command and is entered from ST_IDLE when chip-enable rises. ST_WDATA receives bytes and is entered from ST_CMD when the command has the write-enable bit set and the read bit clear. ST_RDATA sends bytes and is entered from ST_CMD when the read bit is set. ST_HOLD ignores the serial clock. It is entered from ST_CMD on a write command whose enable bit is clear, and from ST_WDATA after the last byte of a single or burst write. Every state returns to ST_IDLE when chip-enable drops.

Top module: `tws_slave`

## Requirements
- R1: The command byte arrives least significant bit first. Bit 0 = 1 selects read and 0 selects write. Bits 5:1 are the address. Bit 6 = 1 selects RAM and 0 selects clock space. Bit 7 = 0 turns a write command into a no-op: no byte is stored and no load strobe is produced.
- R2: Input bits are taken on serial clock rising edges. Read data goes out least significant bit first, one bit per falling edge, and the first bit appears on the falling edge that follows the last command bit.
- R3: `dio_oe` is 0 whenever chip-enable is low and after every serial clock rising edge. It is 1 only after a falling edge during a read.
- R4: After the data byte of a single-byte write, further serial clock cycles store nothing. After a single-byte read, further cycles repeat the same byte.
- R5: Address 31 selects burst, starting at address 0. A clock burst covers the seven time bytes and then the control byte (addresses 0 to 7), and a burst read wraps from 7 back to 0. A RAM burst covers addresses 0 to 30.
- R6: A clock burst write takes effect only if all eight bytes arrive before chip-enable drops. A RAM burst write stores every byte that was fully received.
- R7: Bit 7 of the control byte (address 7) is write-protect, and bits 6:0 always read 0. While write-protect is set, every write is dropped except a single-byte write to the control byte. A clock burst write is dropped as well, including its control byte. Write-protect is 1 after reset.
- R8: The time bytes read back are the values present on `live_time` at the rising edge of chip-enable. Later changes on `live_time` during the same transfer do not affect them.
- R9: Written time bytes reach the counter only after chip-enable falls. `load_stb` pulses once, `load_mask` bit k marks byte k, and `load_data` byte k carries the value. A byte cut short by chip-enable dropping is discarded.
- R10: Clock-space address 8 is an 8-bit configuration byte that can be written and read back. A clock burst never touches it. Clock-space addresses 9 to 30 read as 0.
- R11: After reset, `dio_oe` and `load_stb` are 0 and every RAM byte and the configuration byte read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_pin | input | 1 | Chip-enable from the serial port |
| sclk_pin | input | 1 | Serial clock from the serial port |
| dio_in | input | 1 | Data line value as seen at the pin |
| dio_out | output | 1 | Data value driven onto the line during reads |
| dio_oe | output | 1 | Drive enable for the data line |
| live_time | input | TIME_REGS*BYTE_W | Current time bytes from the counter, byte k at bits 8k+7:8k |
| load_stb | output | 1 | One-cycle strobe that loads the counter |
| load_mask | output | TIME_REGS | Bytes to load, one bit per time byte |
| load_data | output | TIME_REGS*BYTE_W | Time byte values to load |

## Verification
The pins pass through two synchronizer flops and an edge register before the engine acts on them. A read bit is therefore stable on `dio_out`, and `dio_oe` has dropped after a rising edge, about three system cycles after the pin edge. The bench samples six system cycles after each serial clock edge, well before the next edge. `load_stb` follows the chip-enable fall by about four cycles, and the bench waits twelve cycles after dropping chip-enable before it compares the counter model or starts a new transfer. Read bytes go into an expected queue before they are clocked out, and a monitor compares each one as soon as it has been assembled.

// File: rtl/tws_pkg.sv
package tws_pkg;

    localparam int unsigned TWS_BYTE_W = 8;
    localparam int unsigned TWS_ADDR_W = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WDATA,
        ST_RDATA,
        ST_HOLD
    } tws_state_e;

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    logic [W-1:0] pipe [STAGES+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k <= STAGES; k++) pipe[k] <= '0;
        end else begin
            pipe[0] <= async_in;
            for (int k = 1; k <= STAGES; k++) pipe[k] <= pipe[k-1];
        end
    end

    assign lvl  = pipe[STAGES-1];
    assign rise = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall = ~pipe[STAGES-1] & pipe[STAGES];

endmodule

// File: rtl/tws_engine.sv
module tws_engine
    import tws_pkg::*;
#(
    parameter int unsigned BYTE_W    = TWS_BYTE_W,
    parameter int unsigned ADDR_W    = TWS_ADDR_W,
    parameter int unsigned CLK_REGS  = 8,
    parameter int unsigned RAM_BYTES = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_lvl,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              din,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              wr_stb,
    output logic              wr_ram,
    output logic              wr_burst,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              acc_ram,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              dout,
    output logic              doe
);

    localparam int unsigned CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0]  CNT_LAST   = CNT_W'(BYTE_W - 1);
    localparam logic [ADDR_W-1:0] BURST_A    = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] CLK_LAST_A = ADDR_W'(CLK_REGS - 1);
    localparam logic [ADDR_W-1:0] RAM_LAST_A = ADDR_W'(RAM_BYTES - 1);
    localparam int unsigned RD_BIT  = 0;
    localparam int unsigned RAM_BIT = ADDR_W + 1;
    localparam int unsigned WE_BIT  = ADDR_W + 2;

    tws_state_e        state, nxt;
    logic [BYTE_W-1:0] cmd_sh, dat_sh;
    logic [BYTE_W-1:0] cmd_full, dat_full;
    logic [CNT_W-1:0]  bit_cnt;
    logic [ADDR_W-1:0] addr;
    logic              is_ram, is_burst;
    logic              byte_end, last_addr;

    assign cmd_full  = {din, cmd_sh[BYTE_W-1:1]};
    assign dat_full  = {din, dat_sh[BYTE_W-1:1]};
    assign byte_end  = sck_rise && (bit_cnt == CNT_LAST);
    assign last_addr = !is_burst || (addr == (is_ram ? RAM_LAST_A : CLK_LAST_A));
    assign acc_ram   = is_ram;
    assign acc_addr  = addr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (ce_lvl) nxt = ST_CMD;
            ST_CMD: begin
                if (!ce_lvl) nxt = ST_IDLE;
                else if (byte_end) begin
                    if (cmd_full[RD_BIT])      nxt = ST_RDATA;
                    else if (cmd_full[WE_BIT]) nxt = ST_WDATA;
                    else                       nxt = ST_HOLD;
                end
            end
            ST_WDATA: begin
                if (!ce_lvl) nxt = ST_IDLE;
                else if (byte_end && last_addr) nxt = ST_HOLD;
            end
            ST_RDATA: if (!ce_lvl) nxt = ST_IDLE;
            ST_HOLD:  if (!ce_lvl) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_sh   <= '0;
            dat_sh   <= '0;
            bit_cnt  <= '0;
            addr     <= '0;
            is_ram   <= 1'b0;
            is_burst <= 1'b0;
            wr_stb   <= 1'b0;
            wr_ram   <= 1'b0;
            wr_burst <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            dout     <= 1'b0;
            doe      <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    bit_cnt <= '0;
                end
                ST_CMD: begin
                    if (sck_rise) begin
                        cmd_sh  <= cmd_full;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == CNT_LAST) begin
                            is_ram   <= cmd_full[RAM_BIT];
                            is_burst <= (cmd_full[ADDR_W:1] == BURST_A);
                            addr     <= (cmd_full[ADDR_W:1] == BURST_A) ? '0 : cmd_full[ADDR_W:1];
                        end
                    end
                end
                ST_WDATA: begin
                    if (sck_rise) begin
                        dat_sh  <= dat_full;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == CNT_LAST) begin
                            wr_stb   <= 1'b1;
                            wr_data  <= dat_full;
                            wr_addr  <= addr;
                            wr_ram   <= is_ram;
                            wr_burst <= is_burst;
                            addr     <= addr + 1'b1;
                        end
                    end
                end
                ST_RDATA: begin
                    if (sck_rise) begin
                        doe <= 1'b0;
                    end else if (sck_fall) begin
                        doe     <= 1'b1;
                        dout    <= rd_data[bit_cnt];
                        bit_cnt <= bit_cnt + 1'b1;
                        if ((bit_cnt == CNT_LAST) && is_burst) begin
                            addr <= last_addr ? '0 : addr + 1'b1;
                        end
                    end
                end
                ST_HOLD: begin
                    bit_cnt <= '0;
                end
                default: bit_cnt <= '0;
            endcase
            if (!ce_lvl) begin
                doe     <= 1'b0;
                bit_cnt <= '0;
            end
        end
    end

    // R4: once settled in the hold state no further byte is accepted
    a_r4_hold_accepts_nothing: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && $past(state) == ST_HOLD) |-> !wr_stb);

    // R11: the line is never driven while idle
    a_r11_idle_not_driving: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !doe);

    // R2: driving starts only right after a serial clock falling edge
    a_r2_drive_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(doe) |-> $past(sck_fall));

endmodule

// File: rtl/tws_clkregs.sv
module tws_clkregs
    import tws_pkg::*;
#(
    parameter int unsigned TIME_REGS = 7,
    parameter int unsigned BYTE_W    = TWS_BYTE_W,
    parameter int unsigned ADDR_W    = TWS_ADDR_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ce_rise,
    input  logic                        ce_fall,
    input  logic [TIME_REGS*BYTE_W-1:0] live_time,
    input  logic                        wr_stb,
    input  logic                        wr_ram,
    input  logic                        wr_burst,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [BYTE_W-1:0]           wr_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [BYTE_W-1:0]           rd_data,
    output logic                        wp,
    output logic                        load_stb,
    output logic [TIME_REGS-1:0]        load_mask,
    output logic [TIME_REGS*BYTE_W-1:0] load_data
);

    localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(TIME_REGS);
    localparam logic [ADDR_W-1:0] AUX_A = ADDR_W'(TIME_REGS + 1);

    logic [BYTE_W-1:0]    ubuf [TIME_REGS];
    logic [TIME_REGS-1:0] stage_mask;
    logic                 ctl_stage, ctl_pend;
    logic [BYTE_W-1:0]    aux_stage, aux_q;
    logic                 aux_pend;
    logic                 burst_sess, burst_full;
    logic                 clk_wr, ok_time, ok_ctl;

    assign clk_wr  = wr_stb && !wr_ram;
    assign ok_time = burst_sess ? (burst_full && !wp) : !wp;
    assign ok_ctl  = burst_sess ? (burst_full && !wp) : 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < TIME_REGS; k++) ubuf[k] <= '0;
            stage_mask <= '0;
            ctl_stage  <= 1'b0;
            ctl_pend   <= 1'b0;
            aux_stage  <= '0;
            aux_pend   <= 1'b0;
            aux_q      <= '0;
            burst_sess <= 1'b0;
            burst_full <= 1'b0;
            wp         <= 1'b1;
            load_stb   <= 1'b0;
            load_mask  <= '0;
        end else begin
            load_stb <= 1'b0;
            if (ce_rise) begin
                for (int k = 0; k < TIME_REGS; k++) ubuf[k] <= live_time[k*BYTE_W +: BYTE_W];
                stage_mask <= '0;
                ctl_pend   <= 1'b0;
                aux_pend   <= 1'b0;
                burst_sess <= 1'b0;
                burst_full <= 1'b0;
            end else if (clk_wr) begin
                for (int k = 0; k < TIME_REGS; k++) begin
                    if (wr_addr == ADDR_W'(k)) begin
                        ubuf[k]       <= wr_data;
                        stage_mask[k] <= 1'b1;
                    end
                end
                if (wr_addr == CTL_A) begin
                    ctl_stage <= wr_data[BYTE_W-1];
                    ctl_pend  <= 1'b1;
                end
                if (wr_addr == AUX_A) begin
                    aux_stage <= wr_data;
                    aux_pend  <= 1'b1;
                end
                if (wr_burst) begin
                    burst_sess <= 1'b1;
                    if (wr_addr == CTL_A) burst_full <= 1'b1;
                end
            end else if (ce_fall) begin
                if (ok_time) begin
                    load_stb  <= |stage_mask;
                    load_mask <= stage_mask;
                    if (aux_pend) aux_q <= aux_stage;
                end
                if (ctl_pend && ok_ctl) wp <= ctl_stage;
            end
        end
    end

    for (genvar g = 0; g < TIME_REGS; g++) begin : g_load
        assign load_data[g*BYTE_W +: BYTE_W] = ubuf[g];
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < TIME_REGS; k++) begin
            if (rd_addr == ADDR_W'(k)) rd_data = ubuf[k];
        end
        if (rd_addr == CTL_A) rd_data = {wp, {(BYTE_W-1){1'b0}}};
        if (rd_addr == AUX_A) rd_data = aux_q;
    end

    // R9: the counter is loaded only right after chip-enable falls
    a_r9_load_follows_fall: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> $past(ce_fall));

    // R6: a load always carries at least one byte
    a_r6_load_has_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> (load_mask != '0));

    // R7: write-protect is raised only at the end of a transfer
    a_r7_wp_set_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wp) |-> $past(ce_fall));

endmodule

// File: rtl/tws_scratch.sv
module tws_scratch
    import tws_pkg::*;
#(
    parameter int unsigned DEPTH  = 31,
    parameter int unsigned BYTE_W = TWS_BYTE_W,
    parameter int unsigned ADDR_W = TWS_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [BYTE_W-1:0] rdata
);

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else if (we) begin
            for (int k = 0; k < DEPTH; k++) begin
                if (waddr == ADDR_W'(k)) mem[k] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (raddr == ADDR_W'(k)) rdata = mem[k];
        end
    end

endmodule

// File: rtl/tws_slave.sv
module tws_slave
    import tws_pkg::*;
#(
    parameter int unsigned TIME_REGS   = 7,
    parameter int unsigned RAM_BYTES   = 31,
    parameter int unsigned BYTE_W      = TWS_BYTE_W,
    parameter int unsigned ADDR_W      = TWS_ADDR_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ce_pin,
    input  logic                        sclk_pin,
    input  logic                        dio_in,
    output logic                        dio_out,
    output logic                        dio_oe,
    input  logic [TIME_REGS*BYTE_W-1:0] live_time,
    output logic                        load_stb,
    output logic [TIME_REGS-1:0]        load_mask,
    output logic [TIME_REGS*BYTE_W-1:0] load_data
);

    localparam int unsigned CLK_REGS = TIME_REGS + 1;

    logic [2:0]        s_lvl, s_rise, s_fall;
    logic              ce_lvl, sck_rise, sck_fall, din;
    logic              sync_unused;
    logic              wr_stb, wr_ram, wr_burst, acc_ram, wp;
    logic [ADDR_W-1:0] wr_addr, acc_addr;
    logic [BYTE_W-1:0] wr_data, clk_rd, ram_rd, rd_data;
    logic              ram_we;

    tws_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ce_pin, sclk_pin, dio_in}),
        .lvl      (s_lvl),
        .rise     (s_rise),
        .fall     (s_fall)
    );

    assign din         = s_lvl[0];
    assign sck_rise    = s_rise[1];
    assign sck_fall    = s_fall[1];
    assign ce_lvl      = s_lvl[2];
    assign sync_unused = ^{s_rise[0], s_fall[0], s_lvl[1]};

    tws_engine #(
        .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .CLK_REGS(CLK_REGS), .RAM_BYTES(RAM_BYTES)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_lvl   (ce_lvl),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .din      (din),
        .rd_data  (rd_data),
        .wr_stb   (wr_stb),
        .wr_ram   (wr_ram),
        .wr_burst (wr_burst),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .acc_ram  (acc_ram),
        .acc_addr (acc_addr),
        .dout     (dio_out),
        .doe      (dio_oe)
    );

    tws_clkregs #(.TIME_REGS(TIME_REGS), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_clkregs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_rise   (s_rise[2]),
        .ce_fall   (s_fall[2]),
        .live_time (live_time),
        .wr_stb    (wr_stb),
        .wr_ram    (wr_ram),
        .wr_burst  (wr_burst),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (acc_addr),
        .rd_data   (clk_rd),
        .wp        (wp),
        .load_stb  (load_stb),
        .load_mask (load_mask),
        .load_data (load_data)
    );

    assign ram_we = wr_stb && wr_ram && !wp;

    tws_scratch #(.DEPTH(RAM_BYTES), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_scratch (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (acc_addr),
        .rdata (ram_rd)
    );

    assign rd_data = acc_ram ? ram_rd : clk_rd;

    // R3: line released one cycle after chip-enable is seen low
    a_r3_release_ce_low: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_lvl |=> !dio_oe);

    // R3: line released after each serial clock rising edge
    a_r3_release_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_lvl && sck_rise) |=> !dio_oe);

endmodule

// File: tb/tws_slave_bench.sv
module tws_slave_bench;

    localparam int NT = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_pin = 1'b0, sclk_pin = 1'b0, dio_in = 1'b0;
    logic          dio_out, dio_oe, load_stb;
    logic [NT-1:0] load_mask;
    logic [NT*8-1:0] live_time, load_data;

    logic [7:0] live_m [NT];
    logic       poke_en = 1'b0;
    int         poke_idx = 0;
    logic [7:0] poke_val = '0;
    int         load_cnt;
    logic [NT-1:0] last_mask;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] got_byte;
    event       cap_ev;

    int drv_checks = 0, drv_errs = 0, sb_checks = 0, sb_errs = 0;
    logic done = 1'b0, wd_fired = 1'b0;

    always #2 clk = ~clk;

    tws_slave u_tws_slave (
        .clk(clk), .rst_n(rst_n), .ce_pin(ce_pin), .sclk_pin(sclk_pin),
        .dio_in(dio_in), .dio_out(dio_out), .dio_oe(dio_oe),
        .live_time(live_time), .load_stb(load_stb), .load_mask(load_mask),
        .load_data(load_data)
    );

    always_comb for (int k = 0; k < NT; k++) live_time[k*8 +: 8] = live_m[k];

    // time counter model: takes loads from the block and pokes from the driver
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NT; k++) live_m[k] <= 8'h10 + 8'(k);
            load_cnt  <= 0;
            last_mask <= '0;
        end else if (load_stb) begin
            for (int k = 0; k < NT; k++) if (load_mask[k]) live_m[k] <= load_data[k*8 +: 8];
            load_cnt  <= load_cnt + 1;
            last_mask <= load_mask;
        end else if (poke_en) begin
            live_m[poke_idx] <= poke_val;
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(cap_ev);
            sb_checks++;
            if (exp_q.size() == 0) begin
                sb_errs++;
                $display("FAIL scoreboard: got %h expected nothing", got_byte);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (got_byte !== e) begin
                    sb_errs++;
                    $display("FAIL %s: got %h expected %h", t, got_byte, e);
                end
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic dchk(logic [31:0] act, logic [31:0] exp, string tag);
        drv_checks++;
        if (act !== exp) begin
            drv_errs++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send_bit(logic b);
        dio_in = b; tick(4); sclk_pin = 1'b1; tick(8); sclk_pin = 1'b0; tick(4);
    endtask

    task automatic send_byte(logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic begin_xfer(logic [7:0] cmd);
        ce_pin = 1'b1; tick(8); send_byte(cmd);
    endtask

    task automatic end_xfer;
        sclk_pin = 1'b0; dio_in = 1'b0; ce_pin = 1'b0; tick(12);
    endtask

    task automatic poke(int idx, logic [7:0] v);
        poke_idx = idx; poke_val = v; poke_en = 1'b1; tick(1); poke_en = 1'b0; tick(1);
    endtask

    // R2 R3: read one byte, LSB first, checking drive and release timing
    task automatic read_byte(logic [7:0] exp, string tag);
        logic [7:0] v;
        logic oe_ok, rel_ok;
        oe_ok = 1'b1; rel_ok = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        for (int i = 0; i < 8; i++) begin
            tick(6);
            v[i] = dio_out;
            oe_ok &= dio_oe;
            sclk_pin = 1'b1; tick(6);
            rel_ok &= !dio_oe;
            tick(2); sclk_pin = 1'b0;
        end
        got_byte = v;
        ->cap_ev;
        dchk({31'd0, oe_ok}, 32'd1, "R3 drive after fall");
        dchk({31'd0, rel_ok}, 32'd1, "R3 release after rise");
    endtask

    task automatic wr1(logic [7:0] cmd, logic [7:0] d);
        begin_xfer(cmd); send_byte(d); end_xfer();
    endtask

    task automatic rd1(logic [7:0] cmd, logic [7:0] exp, string tag);
        begin_xfer(cmd); read_byte(exp, tag); end_xfer();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        wd_fired = 1'b1;
    end

    initial begin
        int lc;
        tick(5);
        dchk({31'd0, dio_oe}, 0, "R11 reset oe");
        dchk({31'd0, load_stb}, 0, "R11 reset load");
        rst_n = 1'b1; tick(5);

        rd1(8'h8F, 8'h80, "R7 control after reset");
        rd1(8'hC7, 8'h00, "R11 RAM reset value");
        rd1(8'h91, 8'h00, "R11 config reset value");

        // R7: write-protect blocks time and RAM writes
        lc = load_cnt;
        wr1(8'h80, 8'h12);
        dchk(load_cnt, lc, "R7 wp blocks time write");
        wr1(8'hC6, 8'h5A);
        rd1(8'hC7, 8'h00, "R7 wp blocks RAM write");

        // R7: control byte low bits read zero; wp cleared by single write
        wr1(8'h8E, 8'h7F);
        rd1(8'h8F, 8'h00, "R7 low bits zero, wp cleared");
        wr1(8'h8E, 8'hFF);
        rd1(8'h8F, 8'h80, "R7 only bit7 kept");
        wr1(8'h8E, 8'h00);

        // R9: single time write committed on chip-enable fall
        lc = load_cnt;
        wr1(8'h82, 8'h34);
        dchk(load_cnt, lc + 1, "R9 one load");
        dchk({25'd0, last_mask}, 32'h02, "R9 load mask");
        dchk({24'd0, live_m[1]}, 32'h34, "R9 loaded value");
        rd1(8'h83, 8'h34, "R1 R2 read minutes");

        // R8: snapshot at chip-enable rise
        poke(0, 8'h21);
        begin_xfer(8'h81);
        poke(0, 8'h55);
        read_byte(8'h21, "R8 snapshot holds");
        end_xfer();
        rd1(8'h81, 8'h55, "R8 new snapshot");

        // R4: extra cycles after single write ignored; single read repeats
        begin_xfer(8'hC4); send_byte(8'h11); send_byte(8'h99); end_xfer();
        wr1(8'hCA, 8'hA5);
        rd1(8'hC5, 8'h11, "R4 first byte stored");
        rd1(8'hC7, 8'h00, "R4 extra byte ignored");
        begin_xfer(8'hCB);
        read_byte(8'hA5, "R4 read byte");
        read_byte(8'hA5, "R4 read repeats");
        end_xfer();

        // R6 R5: RAM burst write keeps complete bytes
        begin_xfer(8'hFE);
        send_byte(8'h01); send_byte(8'h02); send_byte(8'h03);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        end_xfer();
        rd1(8'hC7, 8'h00, "R6 partial RAM byte dropped");
        begin_xfer(8'hFF);
        read_byte(8'h01, "R5 RAM burst 0");
        read_byte(8'h02, "R5 RAM burst 1");
        read_byte(8'h03, "R5 RAM burst 2");
        read_byte(8'h00, "R5 RAM burst 3");
        read_byte(8'h00, "R5 RAM burst 4");
        read_byte(8'hA5, "R5 RAM burst 5");
        end_xfer();

        // R6: clock burst needs all eight bytes
        lc = load_cnt;
        begin_xfer(8'hBE);
        for (int i = 0; i < 7; i++) send_byte(8'h40 + 8'(i));
        end_xfer();
        dchk(load_cnt, lc, "R6 short clock burst dropped");
        begin_xfer(8'hBE);
        send_byte(8'h45); send_byte(8'h59); send_byte(8'h23); send_byte(8'h31);
        send_byte(8'h12); send_byte(8'h07); send_byte(8'h99); send_byte(8'h00);
        end_xfer();
        dchk(load_cnt, lc + 1, "R6 full clock burst loads");
        dchk({25'd0, last_mask}, 32'h7F, "R6 burst mask");
        dchk({24'd0, live_m[6]}, 32'h99, "R6 burst last value");

        // R10: config byte storage, empty addresses
        wr1(8'h90, 8'hA5);
        rd1(8'h91, 8'hA5, "R10 config readback");
        rd1(8'h99, 8'h00, "R10 address 12 reads zero");

        // R5: clock burst read covers 0..7 then wraps, config excluded
        begin_xfer(8'hBF);
        read_byte(8'h45, "R5 clk burst 0");
        read_byte(8'h59, "R5 clk burst 1");
        read_byte(8'h23, "R5 clk burst 2");
        read_byte(8'h31, "R5 clk burst 3");
        read_byte(8'h12, "R5 clk burst 4");
        read_byte(8'h07, "R5 clk burst 5");
        read_byte(8'h99, "R5 clk burst 6");
        read_byte(8'h00, "R5 clk burst control");
        read_byte(8'h45, "R5 clk burst wraps");
        end_xfer();

        // R1: write-enable bit clear means no write
        lc = load_cnt;
        wr1(8'h02, 8'h77);
        dchk(load_cnt, lc, "R1 bit7 clear blocks time write");
        wr1(8'h4A, 8'h3C);
        rd1(8'hCB, 8'hA5, "R1 bit7 clear blocks RAM write");

        // R9: byte cut short by chip-enable is discarded
        lc = load_cnt;
        begin_xfer(8'h80);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        end_xfer();
        dchk(load_cnt, lc, "R9 aborted byte no load");
        dchk({31'd0, dio_oe}, 0, "R3 released with chip-enable low");

        // R7: burst write blocked while protected, control byte included
        wr1(8'h8E, 8'h80);
        lc = load_cnt;
        begin_xfer(8'hBE);
        for (int i = 0; i < 7; i++) send_byte(8'h01);
        send_byte(8'h00);
        end_xfer();
        dchk(load_cnt, lc, "R7 protected burst no load");
        rd1(8'h8F, 8'h80, "R7 protected burst keeps wp");

        tick(10);
        done = 1'b1;
    end

    initial begin
        int errs;
        wait (done || wd_fired);
        tick(2);
        errs = drv_errs + sb_errs;
        if (wd_fired && !done) begin
            errs++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors",
                 drv_checks + sb_checks + (wd_fired && !done ? 1 : 0), errs);
        $finish;
    end

endmodule